// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

An eight-input interrupt controller that takes rising edges on its request inputs and passes the most urgent unmasked one on to whatever it reports to. Each instance holds a request register, an in-service register and a mask register, and it resolves them with a fixed priority: input 0 is the most urgent and input 7 the least. One configuration bit sets the instance's role. A master sends its output to the CPU. A slave sends its output to one request input of a master. A master resolves a cascaded input like any other input.

The CPU acknowledges an interrupt with two single-cycle pulses on `inta_i`. On the first pulse, the owning controller clears the selected request bit and sets the matching in-service bit. When a master's selected level has a slave attached, the master drives that level number on the 3-bit cascade bus for that cycle. The slave whose programmed ID matches the bus takes the first pulse as its own. On the second pulse, the owning controller emits an 8-bit vector. The vector is the programmed base with its low 3 bits replaced by the level. An end-of-interrupt command retires the most urgent in-service level.

Configuration uses a write-only port with four addresses. Address 0 is control, where bit 0 set selects the master role. Address 1 is cascade: on a master it holds the slave-present map, one bit per level; on a slave its low 3 bits hold the own ID. Address 2 is the vector base. Address 3 is the mask, where a set bit masks that level.

Top module: `cascade_pic`

## Requirements
- R1: After reset, `int_o`, `cas_oe_o` and `vec_valid_o` are low, no request or in-service bit is set, all levels are unmasked, and the role is slave with ID 0, an empty map and base 0.
- R2: A low-to-high transition on `ir_i[k]` sets request bit k. An input that stays high does not request again once its request has been acknowledged.
- R3: Among the unmasked pending requests, the lowest index wins, so level 0 has the highest priority.
- R4: A pending request is forwarded only if no in-service bit of equal or higher priority (equal or lower index) is set. A request of higher priority still gets through while a lower level is in service.
- R5: `int_o` goes high two clock edges after a rising input edge whose request passes resolution. It drops one edge after the acknowledge that clears that request.
- R6: On the first acknowledge pulse taken by the controller, the winning level's request bit is cleared and its in-service bit is set.
- R7: A master whose winning level has a bit set in the slave map drives `cas_oe_o` high and `cas_o` equal to that level while the first pulse is high. Such a master raises no `vec_valid_o` on the second pulse.
- R8: On the second pulse, the owning controller pulses `vec_valid_o` for one cycle after that edge, with `vec_o` = {base[7:3], level}.
- R9: A slave takes the first pulse only when `cas_en_i` is high and `cas_i` equals its ID. Otherwise it ignores both pulses: its requests, `int_o` and `vec_valid_o` are unaffected.
- R10: A pulse on `eoi_i` clears the lowest-index set in-service bit, and only that bit.
- R11: A masked level does not take part in resolution. Its request stays latched and is forwarded once it is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Register select: 0 control, 1 cascade, 2 base, 3 mask |
| cfg_wdata_i | input | 8 | Configuration write data |
| eoi_i | input | 1 | End-of-interrupt pulse |
| ir_i | input | 8 | Edge-sensitive request inputs |
| inta_i | input | 1 | Acknowledge pulse, one cycle per pulse |
| cas_i | input | 3 | Cascade address seen by a slave |
| cas_en_i | input | 1 | Cascade address valid |
| int_o | output | 1 | Interrupt request to the CPU or to the master |
| cas_o | output | 3 | Cascade address driven by a master |
| cas_oe_o | output | 1 | Cascade address valid, from a master |
| vec_o | output | 8 | Interrupt vector |
| vec_valid_o | output | 1 | Vector valid strobe |

## Verification
The assertions check four things on every cycle:
- a request bit appears only after a rising input edge;
- an acknowledge always leaves the winning level in service;
- an end-of-interrupt removes exactly one in-service bit;
- a master never emits a vector for a level it handed to a slave, and the cascade bus and vector strobe appear only around acknowledge pulses.

Only the bench scenarios can show the rest: the priority order across input patterns, blocking and nesting through the in-service register, the effect of masking and unmasking, and a full three-controller cascade in which one slave answers and a second slave with the wrong ID stays pending.

// File: rtl/cpic_pkg.sv
package cpic_pkg;
  typedef enum logic [1:0] {
    CFG_CTRL = 2'd0,
    CFG_CASC = 2'd1,
    CFG_BASE = 2'd2,
    CFG_MASK = 2'd3
  } cfg_sel_e;

  localparam int unsigned CFG_W = 8;
endpackage

// File: rtl/cpic_cfg_regs.sv
module cpic_cfg_regs
  import cpic_pkg::*;
#(
  parameter int unsigned NLVL  = 8,
  parameter int unsigned VEC_W = 8,
  localparam int unsigned LVL_W = $clog2(NLVL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic             is_master_o,
  output logic [NLVL-1:0]  slv_map_o,
  output logic [LVL_W-1:0] own_id_o,
  output logic [VEC_W-1:0] base_o,
  output logic [NLVL-1:0]  mask_o
);
  cfg_sel_e sel;
  assign sel = cfg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is_master_o <= 1'b0;
      slv_map_o   <= '0;
      own_id_o    <= '0;
      base_o      <= '0;
      mask_o      <= '0;
    end else if (we_i) begin
      unique case (sel)
        CFG_CTRL: is_master_o <= wdata_i[0];
        CFG_CASC: begin
          slv_map_o <= wdata_i[NLVL-1:0];
          own_id_o  <= wdata_i[LVL_W-1:0];
        end
        CFG_BASE: base_o <= wdata_i[VEC_W-1:0];
        CFG_MASK: mask_o <= wdata_i[NLVL-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cpic_req_regs.sv
module cpic_req_regs #(
  parameter int unsigned NLVL = 8,
  localparam int unsigned LVL_W = $clog2(NLVL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NLVL-1:0]  ir_i,
  input  logic             ack_set_i,
  input  logic [LVL_W-1:0] ack_lvl_i,
  input  logic             eoi_i,
  output logic [NLVL-1:0]  irr_o,
  output logic [NLVL-1:0]  isr_o
);
  logic [NLVL-1:0] ir_q, irr_q, isr_q, rise, ack_oh, eoi_oh;

  assign rise = ir_i & ~ir_q;

  always_comb begin
    ack_oh = '0;
    if (ack_set_i) ack_oh[ack_lvl_i] = 1'b1;
  end

  // one-hot of the most urgent in-service level
  always_comb begin
    eoi_oh = '0;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (isr_q[i]) begin
        eoi_oh    = '0;
        eoi_oh[i] = 1'b1;
      end
    end
    if (!eoi_i) eoi_oh = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q  <= '0;
      irr_q <= '0;
      isr_q <= '0;
    end else begin
      ir_q  <= ir_i;
      irr_q <= (irr_q & ~ack_oh) | rise;
      isr_q <= (isr_q & ~eoi_oh) | ack_oh;
    end
  end

  assign irr_o = irr_q;
  assign isr_o = isr_q;

  a_r2_req_from_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irr_q & ~$past(irr_q) & ~$past(rise)) == '0));

  a_r6_ack_sets_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_set_i |=> isr_q[$past(ack_lvl_i)]);

  a_r10_eoi_clears_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_set_i && (isr_q != '0)) |=>
      ($countones(isr_q) + 1 == $past($countones(isr_q))));
endmodule

// File: rtl/cpic_resolver.sv
module cpic_resolver #(
  parameter int unsigned NLVL = 8,
  localparam int unsigned LVL_W = $clog2(NLVL)
) (
  input  logic [NLVL-1:0]  irr_i,
  input  logic [NLVL-1:0]  isr_i,
  input  logic [NLVL-1:0]  mask_i,
  output logic             req_ok_o,
  output logic [LVL_W-1:0] req_lvl_o
);
  logic [NLVL-1:0] cand;
  logic            found, blocked;

  assign cand = irr_i & ~mask_i;

  always_comb begin
    found     = 1'b0;
    req_lvl_o = '0;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found     = 1'b1;
        req_lvl_o = LVL_W'(i);
      end
    end
  end

  // in service at equal or higher priority blocks
  always_comb begin
    blocked = 1'b0;
    for (int j = 0; j < NLVL; j++) begin
      if (isr_i[j] && (LVL_W'(j) <= req_lvl_o)) blocked = 1'b1;
    end
  end

  assign req_ok_o = found && !blocked;
endmodule

// File: rtl/cpic_ack_ctrl.sv
module cpic_ack_ctrl #(
  parameter int unsigned NLVL  = 8,
  parameter int unsigned VEC_W = 8,
  localparam int unsigned LVL_W = $clog2(NLVL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inta_i,
  input  logic             is_master_i,
  input  logic [NLVL-1:0]  slv_map_i,
  input  logic [LVL_W-1:0] own_id_i,
  input  logic [VEC_W-1:0] base_i,
  input  logic [LVL_W-1:0] cas_i,
  input  logic             cas_en_i,
  input  logic             req_ok_i,
  input  logic [LVL_W-1:0] req_lvl_i,
  output logic             ack_set_o,
  output logic [LVL_W-1:0] cas_o,
  output logic             cas_oe_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_valid_o
);
  logic             wait2_q, owner_q, vld_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VEC_W-1:0] vec_q;
  logic             first, addressed, take, to_slave;

  assign first     = inta_i && !wait2_q;
  assign addressed = is_master_i || (cas_en_i && (cas_i == own_id_i));
  assign take      = first && addressed && req_ok_i;
  assign to_slave  = is_master_i && slv_map_i[req_lvl_i];

  assign ack_set_o = take;
  assign cas_oe_o  = take && to_slave;
  assign cas_o     = cas_oe_o ? req_lvl_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait2_q <= 1'b0;
      owner_q <= 1'b0;
      lvl_q   <= '0;
      vld_q   <= 1'b0;
      vec_q   <= '0;
    end else begin
      vld_q <= 1'b0;
      if (inta_i) begin
        if (wait2_q) begin
          wait2_q <= 1'b0;
          owner_q <= 1'b0;
          if (owner_q) begin
            vld_q <= 1'b1;
            vec_q <= {base_i[VEC_W-1:LVL_W], lvl_q};
          end
        end else if (addressed) begin
          wait2_q <= 1'b1;
          owner_q <= take && !to_slave;
          lvl_q   <= req_lvl_i;
        end
      end
    end
  end

  assign vec_o       = vec_q;
  assign vec_valid_o = vld_q;

  a_r7_no_vec_for_slave_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_oe_o |=> (wait2_q && !owner_q));

  a_r7_cas_only_in_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_oe_o |-> (inta_i && is_master_i));

  a_r8_vec_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !vec_valid_o);

  a_r8_vec_after_inta: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(inta_i));
endmodule

// File: rtl/cascade_pic.sv
module cascade_pic
  import cpic_pkg::*;
#(
  parameter int unsigned NLVL  = 8,
  parameter int unsigned VEC_W = 8,
  localparam int unsigned LVL_W = $clog2(NLVL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             eoi_i,
  input  logic [NLVL-1:0]  ir_i,
  input  logic             inta_i,
  input  logic [LVL_W-1:0] cas_i,
  input  logic             cas_en_i,
  output logic             int_o,
  output logic [LVL_W-1:0] cas_o,
  output logic             cas_oe_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_valid_o
);
  logic             is_master;
  logic [NLVL-1:0]  slv_map, mask, irr, isr;
  logic [LVL_W-1:0] own_id, req_lvl;
  logic [VEC_W-1:0] base;
  logic             req_ok, ack_set, int_q;

  cpic_cfg_regs #(.NLVL(NLVL), .VEC_W(VEC_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .is_master_o(is_master), .slv_map_o(slv_map), .own_id_o(own_id),
    .base_o(base), .mask_o(mask)
  );

  cpic_req_regs #(.NLVL(NLVL)) u_req (
    .clk_i, .rst_ni, .ir_i,
    .ack_set_i(ack_set), .ack_lvl_i(req_lvl), .eoi_i,
    .irr_o(irr), .isr_o(isr)
  );

  cpic_resolver #(.NLVL(NLVL)) u_res (
    .irr_i(irr), .isr_i(isr), .mask_i(mask),
    .req_ok_o(req_ok), .req_lvl_o(req_lvl)
  );

  cpic_ack_ctrl #(.NLVL(NLVL), .VEC_W(VEC_W)) u_ack (
    .clk_i, .rst_ni, .inta_i,
    .is_master_i(is_master), .slv_map_i(slv_map), .own_id_i(own_id),
    .base_i(base), .cas_i, .cas_en_i,
    .req_ok_i(req_ok), .req_lvl_i(req_lvl),
    .ack_set_o(ack_set), .cas_o, .cas_oe_o, .vec_o, .vec_valid_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) int_q <= 1'b0;
    else         int_q <= req_ok && !ack_set;
  end

  assign int_o = int_q;

  a_r5_int_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> $past((irr & ~mask) != '0));

  a_r11_masked_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_set |-> !mask[req_lvl]);
endmodule

// File: tb/cascade_pic_test.sv
module cascade_pic_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [2:0] we;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [2:0] eoi;
  logic       inta;
  logic [7:0] tb_ir;
  logic       casc;

  logic       m_int, a_int, b_int;
  logic [2:0] m_cas, a_cas, b_cas;
  logic       m_cas_oe, a_cas_oe, b_cas_oe;
  logic [7:0] m_vec, a_vec, b_vec;
  logic       m_vv, a_vv, b_vv;
  logic [7:0] m_ir;
  logic [7:0] a_ir, b_ir;

  assign m_ir = casc ? {a_int, tb_ir[6:4], b_int, tb_ir[2:0]} : tb_ir;

  cascade_pic uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we[0]), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .eoi_i(eoi[0]), .ir_i(m_ir), .inta_i(inta),
    .cas_i(3'd0), .cas_en_i(1'b0), .int_o(m_int), .cas_o(m_cas),
    .cas_oe_o(m_cas_oe), .vec_o(m_vec), .vec_valid_o(m_vv)
  );

  cascade_pic u_slv_a (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we[1]), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .eoi_i(eoi[1]), .ir_i(a_ir), .inta_i(inta),
    .cas_i(m_cas), .cas_en_i(m_cas_oe), .int_o(a_int), .cas_o(a_cas),
    .cas_oe_o(a_cas_oe), .vec_o(a_vec), .vec_valid_o(a_vv)
  );

  cascade_pic u_slv_b (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we[2]), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .eoi_i(eoi[2]), .ir_i(b_ir), .inta_i(inta),
    .cas_i(m_cas), .cas_en_i(m_cas_oe), .int_o(b_int), .cas_o(b_cas),
    .cas_oe_o(b_cas_oe), .vec_o(b_vec), .vec_valid_o(b_vv)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_wr(input int inst, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 3'b000; we[inst] = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 3'b000;
  endtask

  task automatic pulse_eoi(input int inst);
    @(negedge clk);
    eoi = 3'b000; eoi[inst] = 1'b1;
    @(negedge clk);
    eoi = 3'b000;
  endtask

  // two acknowledge pulses; returns master vector sampled after the second
  task automatic ack2(output logic vv, output logic [7:0] v);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    cyc(1);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    #1; vv = m_vv; v = m_vec;
  endtask

  task automatic drain_master();
    logic vv;
    logic [7:0] v;
    cfg_wr(0, 2'd3, 8'h00);
    cyc(3);
    for (int k = 0; k < 9; k++) begin
      if (m_int) begin
        ack2(vv, v);
        pulse_eoi(0);
        cyc(3);
      end
    end
  endtask

  // {ir pattern, mask, expected level}
  localparam logic [23:0] TBL [6] = '{
    {8'h04, 8'h00, 8'd2},
    {8'h81, 8'h00, 8'd0},
    {8'hF0, 8'h00, 8'd4},
    {8'h06, 8'h02, 8'd2},
    {8'h80, 8'h00, 8'd7},
    {8'hC0, 8'h40, 8'd7}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic vv;
    logic [7:0] v;
    we = '0; addr = '0; wdata = '0; eoi = '0; inta = 1'b0;
    tb_ir = '0; casc = 1'b0; a_ir = '0; b_ir = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    check(m_int == 1'b0, "R1 int_o", m_int, 0);
    check(m_vv == 1'b0 && m_cas_oe == 1'b0, "R1 vec/cas idle", {m_vv, m_cas_oe}, 0);
    tb_ir = 8'h20; cyc(3);
    check(m_int == 1'b1, "R1 unmasked after reset", m_int, 1);
    // slave role by default: no acknowledge taken without a cascade address
    ack2(vv, v);
    check(m_int == 1'b1 && vv == 1'b0, "R1 slave role ignores inta", {m_int, vv}, 2);
    tb_ir = '0;

    cfg_wr(0, 2'd0, 8'h01);
    cfg_wr(0, 2'd2, 8'h40);
    drain_master();

    // table of patterns (R3, R11, R8)
    foreach (TBL[i]) begin
      cfg_wr(0, 2'd3, TBL[i][15:8]);
      tb_ir = TBL[i][23:16];
      cyc(3);
      check(m_int == 1'b1, "R5 int raised", m_int, 1);
      ack2(vv, v);
      check(vv == 1'b1, "R8 vector strobe", vv, 1);
      check(v == (8'h40 | TBL[i][7:0]), "R3 winning level vector", v, 8'h40 | TBL[i][7:0]);
      pulse_eoi(0);
      drain_master();
      if (i == 0) check(m_int == 1'b0, "R2 held input no re-request", m_int, 0);
      tb_ir = '0;
      cyc(2);
    end

    // R5 drop after acknowledge, R6 / R4 nesting
    tb_ir = 8'h08; cyc(3);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    #1;
    check(m_int == 1'b0, "R5 int drops after first pulse", m_int, 0);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    #1;
    check(m_vec == 8'h43 && m_vv, "R6 level 3 acknowledged", m_vec, 8'h43);
    tb_ir = 8'h28; cyc(3);
    check(m_int == 1'b0, "R4 lower level blocked by in-service", m_int, 0);
    tb_ir = 8'h2A; cyc(3);
    check(m_int == 1'b1, "R4 higher level nests", m_int, 1);
    ack2(vv, v);
    check(v == 8'h41, "R4 nested vector", v, 8'h41);
    pulse_eoi(0); cyc(3);
    check(m_int == 1'b0, "R10 eoi clears only level 1", m_int, 0);
    pulse_eoi(0); cyc(3);
    check(m_int == 1'b1, "R10 eoi clears level 3 then 5 passes", m_int, 1);
    ack2(vv, v);
    check(v == 8'h45, "R10 level 5 vector", v, 8'h45);
    pulse_eoi(0);
    tb_ir = '0; cyc(2);

    // R11 mask then unmask
    cfg_wr(0, 2'd3, 8'h40);
    tb_ir = 8'h40; cyc(3);
    check(m_int == 1'b0, "R11 masked level blocked", m_int, 0);
    cfg_wr(0, 2'd3, 8'h00); cyc(2);
    check(m_int == 1'b1, "R11 unmask forwards latched request", m_int, 1);
    ack2(vv, v);
    check(v == 8'h46, "R11 vector after unmask", v, 8'h46);
    pulse_eoi(0);
    tb_ir = '0; cyc(2);

    // cascade: slave A id 7 on level 7, slave B id 3 on level 3 (masked at master)
    cfg_wr(0, 2'd1, 8'h88);
    cfg_wr(0, 2'd3, 8'h08);
    cfg_wr(1, 2'd1, 8'h07);
    cfg_wr(1, 2'd2, 8'h20);
    cfg_wr(2, 2'd1, 8'h03);
    cfg_wr(2, 2'd2, 8'h60);
    casc = 1'b1;
    b_ir = 8'h02; cyc(3);
    a_ir = 8'h04; cyc(6);
    check(m_int == 1'b1 && a_int == 1'b1, "R7 cascade int path", {m_int, a_int}, 3);
    @(negedge clk); inta = 1'b1;
    #1;
    check(m_cas_oe == 1'b1 && m_cas == 3'd7, "R7 cascade address", m_cas, 7);
    @(negedge clk); inta = 1'b0;
    #1;
    check(a_int == 1'b0, "R6 slave request cleared", a_int, 0);
    cyc(1);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    #1;
    check(m_vv == 1'b0, "R7 master silent for slave level", m_vv, 0);
    check(a_vv == 1'b1 && a_vec == 8'h22, "R9 addressed slave vector", a_vec, 8'h22);
    check(b_vv == 1'b0 && b_int == 1'b1, "R9 other slave idle", {b_vv, b_int}, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule